// File: doc/BRIEF.md
# Dual-Hart Machine Counter File

This block holds the machine-level counters of a core that runs two harts. One 64-bit cycle counter is shared by both harts. Each hart also owns a 64-bit retired-instruction counter and a bank of programmable 64-bit event counters at indices 3 upward (29 per hart by default). Event selection is done outside the block: each event counter has one pulse input, and it adds one in every clock where that pulse is high. Privilege checks and the real-time counter are handled elsewhere.

Each hart has its own CSR-style port. A read strobe with a 6-bit selector returns the full 64-bit value one clock later. A write strobe replaces the selected counter, or updates the hart's inhibit word. The inhibit word has one bit per counter, and a set bit freezes that counter. The cycle bit of the inhibit word is shared along with the cycle counter, so a write to it by either hart changes it for both. Every other inhibit bit belongs to one hart only. A write made in the same clock as an increment takes the place of that increment, so an instruction that retires while it writes its own retire counter leaves the written value in place.

Top module: `hpm_counter_file`

## Requirements
- R1: The shared cycle counter adds exactly one per clock while the shared cycle inhibit bit is clear, and holds its value while that bit is set.
- R2: A write to selector 0 (cycle) from either hart sets the one shared cycle counter, and both harts read the written value afterwards.
- R3: Bit 0 of the inhibit word (selector 32) is shared: a write from either hart changes the value both harts read and the behaviour both harts see.
- R4: If both harts write the cycle counter, or both write the inhibit word, in the same clock, the shared value takes hart 0's data.
- R5: A hart's retired-instruction counter (selector 2) adds one per clock with that hart's retire pulse high while inhibit bit 2 of that hart is clear. It holds while that bit is set and is unaffected by the other hart.
- R6: Event counter k of a hart (selector k, 3 ≤ k < 3+NUM_EVT) adds exactly one per clock in which event pulse bit k−3 of that hart is high, unless that hart's inhibit bit k is set.
- R7: A write to a counter in the same clock as its increment leaves exactly the written value. Counters wrap from all-ones to zero.
- R8: A read strobe returns, on the next clock, the selected value as it stood before any same-clock write. The read data holds its value when no read is issued.
- R9: Selector 1, selectors 3+NUM_EVT..31 and selectors 33..63 read as zero, and writes to them change no state.
- R10: Inhibit bit 1 and bits above 2+NUM_EVT read as zero and ignore writes. Bit 2 and bits 3..2+NUM_EVT are private to each hart.
- R11: After synchronous reset all counters, all inhibit bits and the read data are zero, so every counter counts from the first clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_re | input | NUM_HARTS | Per-hart read strobe |
| csr_we | input | NUM_HARTS | Per-hart write strobe |
| csr_sel | input | NUM_HARTS×6 | Per-hart selector: 0 cycle, 2 retired, 3.. events, 32 inhibit word |
| csr_wdata | input | NUM_HARTS×CNT_W | Per-hart write data |
| csr_rdata | output | NUM_HARTS×CNT_W | Per-hart read data, one clock after the strobe |
| retire | input | NUM_HARTS | Per-hart one-instruction-retired pulse |
| evt | input | NUM_HARTS×NUM_EVT | Per-hart event pulses, bit i feeds counter 3+i |

## Verification
The bench targets four failure modes. Simultaneous cycle and inhibit writes from both harts check that hart 0 wins; a design that kept hart 1's data would show the wrong shared value to both harts. Writes that land in the same clock as a retire or event pulse check that the write wins; a design that let the increment win would read back the written value plus one. The cross-hart phases check sharing and privacy: a write to the cycle inhibit bit must freeze the other hart's view of the cycle counter, while the retire and event inhibit bits must not reach the other hart. Writes of all-ones followed by an increment check wrap to zero. Writes to the unused selectors and inhibit bits are followed by full read-backs, which catch any stray state change or a nonzero read of a reserved position.

// File: rtl/hpm_pkg.sv
// Shared constants for the dual-hart counter file: selector codes and
// inhibit-word bit positions. Assumes a 6-bit selector space.
package hpm_pkg;
    localparam int SEL_W = 6;
    localparam logic [SEL_W-1:0] SEL_CYC  = 6'd0;   // shared cycle counter
    localparam logic [SEL_W-1:0] SEL_IR   = 6'd2;   // retired-instruction counter
    localparam int               SEL_EV0  = 3;      // first event counter
    localparam logic [SEL_W-1:0] SEL_INH  = 6'd32;  // inhibit word
    localparam int INH_CY  = 0;
    localparam int INH_IR  = 2;
    localparam int INH_EV0 = 3;
endpackage

// File: rtl/hpm_shared_cycle.sv
// Shared cycle counter and its shared inhibit bit.
// Assumes: cyc_we/cy_we are already decoded per hart; the lowest-numbered
// hart has priority when several harts write in one clock.
module hpm_shared_cycle #(
    parameter int NUM_HARTS = 2,
    parameter int CNT_W     = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_HARTS-1:0]             cyc_we,
    input  logic [NUM_HARTS-1:0]             cy_we,
    input  logic [NUM_HARTS-1:0][CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]                 cyc_q,
    output logic                             cy_q
);
    logic [CNT_W-1:0] cyc_nxt;
    logic             cy_nxt;

    // Next state: count unless inhibited, then let writes override, hart 0 last.
    always_comb begin
        cyc_nxt = cy_q ? cyc_q : cyc_q + CNT_W'(1);
        cy_nxt  = cy_q;
        for (int h = NUM_HARTS - 1; h >= 0; h--) begin
            if (cyc_we[h]) cyc_nxt = wdata[h];
            if (cy_we[h])  cy_nxt  = wdata[h][0];
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            cy_q  <= 1'b0;
        end else begin
            cyc_q <= cyc_nxt;
            cy_q  <= cy_nxt;
        end
    end

    // R1
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_q && cyc_we == '0) |=> $stable(cyc_q));
    // R1
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cy_q && cyc_we == '0) |=> (cyc_q == $past(cyc_q) + CNT_W'(1)));
    // R4
    cyc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_we[0] |=> (cyc_q == $past(wdata[0])));
    // R4
    cy_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cy_we[0] |=> (cy_q == $past(wdata[0][0])));
endmodule

// File: rtl/hpm_hart_bank.sv
// Private counters of one hart: retired-instruction counter, event counters
// and the private inhibit bits, plus the registered read path.
// Assumes: the shared cycle value and shared inhibit bit come from outside;
// NUM_EVT <= 29 and CNT_W >= 32.
module hpm_hart_bank
    import hpm_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int NUM_EVT = 29
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 re,
    input  logic                 we,
    input  logic [SEL_W-1:0]     sel,
    input  logic [CNT_W-1:0]     wdata,
    input  logic                 retire,
    input  logic [NUM_EVT-1:0]   evt,
    input  logic [CNT_W-1:0]     cyc_val,
    input  logic                 cy_inh,
    output logic [CNT_W-1:0]     rdata
);
    logic [CNT_W-1:0]   ir_q;
    logic [CNT_W-1:0]   ev_q [NUM_EVT];
    logic               ir_inh_q;
    logic [NUM_EVT-1:0] ev_inh_q;
    logic [31:0]        inh_word;
    logic [CNT_W-1:0]   rd_val;
    logic               wr_ir, wr_inh;

    assign wr_ir  = we && (sel == SEL_IR);
    assign wr_inh = we && (sel == SEL_INH);

    // Retired-instruction counter: write replaces the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ir_q <= '0;
        else if (wr_ir)                ir_q <= wdata;
        else if (retire && !ir_inh_q)  ir_q <= ir_q + CNT_W'(1);
    end

    // Event counters: one step per clock per active pulse, write wins.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_EVT; k++) begin
            if (!rst_n)
                ev_q[k] <= '0;
            else if (we && (sel == SEL_W'(SEL_EV0 + k)))
                ev_q[k] <= wdata;
            else if (evt[k] && !ev_inh_q[k])
                ev_q[k] <= ev_q[k] + CNT_W'(1);
        end
    end

    // Private inhibit bits, loaded from the inhibit-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_inh_q <= 1'b0;
            ev_inh_q <= '0;
        end else if (wr_inh) begin
            ir_inh_q <= wdata[INH_IR];
            ev_inh_q <= wdata[INH_EV0 +: NUM_EVT];
        end
    end

    // Inhibit word as seen by this hart; reserved bits stay zero.
    always_comb begin
        inh_word                    = '0;
        inh_word[INH_CY]            = cy_inh;
        inh_word[INH_IR]            = ir_inh_q;
        inh_word[INH_EV0 +: NUM_EVT] = ev_inh_q;
    end

    // Read selector decode; unmapped selectors return zero.
    always_comb begin
        rd_val = '0;
        if (sel == SEL_INH)      rd_val[31:0] = inh_word;
        else if (sel == SEL_CYC) rd_val = cyc_val;
        else if (sel == SEL_IR)  rd_val = ir_q;
        else begin
            for (int k = 0; k < NUM_EVT; k++)
                if (sel == SEL_W'(SEL_EV0 + k)) rd_val = ev_q[k];
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= rd_val;
    end

    // R7
    ir_wr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ir |=> (ir_q == $past(wdata)));
    // R5
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_inh_q && !wr_ir) |=> $stable(ir_q));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
    // R10
    inh_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sel == SEL_INH) |=> (rdata[1] == 1'b0 && rdata[CNT_W-1:32] == '0));
    // R9
    sel_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sel == 6'd1) |=> (rdata == '0));
endmodule

// File: rtl/hpm_counter_file.sv
// Top of the dual-hart counter file: decodes per-hart writes aimed at the
// shared cycle state and instantiates one private bank per hart.
// Assumes: one CSR access per hart per clock; selectors from hpm_pkg.
module hpm_counter_file
    import hpm_pkg::*;
#(
    parameter int NUM_HARTS = 2,
    parameter int CNT_W     = 64,
    parameter int NUM_EVT   = 29
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_HARTS-1:0]                csr_re,
    input  logic [NUM_HARTS-1:0]                csr_we,
    input  logic [NUM_HARTS-1:0][SEL_W-1:0]     csr_sel,
    input  logic [NUM_HARTS-1:0][CNT_W-1:0]     csr_wdata,
    output logic [NUM_HARTS-1:0][CNT_W-1:0]     csr_rdata,
    input  logic [NUM_HARTS-1:0]                retire,
    input  logic [NUM_HARTS-1:0][NUM_EVT-1:0]   evt
);
    logic [NUM_HARTS-1:0] cyc_we;
    logic [NUM_HARTS-1:0] cy_we;
    logic [CNT_W-1:0]     cyc_val;
    logic                 cy_inh;

    // Per-hart decode of writes that touch the shared state.
    always_comb begin
        for (int h = 0; h < NUM_HARTS; h++) begin
            cyc_we[h] = csr_we[h] && (csr_sel[h] == SEL_CYC);
            cy_we[h]  = csr_we[h] && (csr_sel[h] == SEL_INH);
        end
    end

    hpm_shared_cycle #(.NUM_HARTS(NUM_HARTS), .CNT_W(CNT_W)) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .cyc_we (cyc_we),
        .cy_we  (cy_we),
        .wdata  (csr_wdata),
        .cyc_q  (cyc_val),
        .cy_q   (cy_inh)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        hpm_hart_bank #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .re      (csr_re[h]),
            .we      (csr_we[h]),
            .sel     (csr_sel[h]),
            .wdata   (csr_wdata[h]),
            .retire  (retire[h]),
            .evt     (evt[h]),
            .cyc_val (cyc_val),
            .cy_inh  (cy_inh),
            .rdata   (csr_rdata[h])
        );
    end

    // R2
    cyc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_re[0] && csr_sel[0] == SEL_CYC) |=> (csr_rdata[0] == $past(cyc_val)));
endmodule

// File: tb/tb_hpm_counter_file.sv
module tb_hpm_counter_file;
    localparam int  H = 2;
    localparam int  W = 64;
    localparam int  E = 29;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [H-1:0]        csr_re = '0, csr_we = '0, retire = '0;
    logic [H-1:0][5:0]   csr_sel = '0;
    logic [H-1:0][W-1:0] csr_wdata = '0;
    logic [H-1:0][W-1:0] csr_rdata;
    logic [H-1:0][E-1:0] evt = '0;

    hpm_counter_file #(.NUM_HARTS(H), .CNT_W(W), .NUM_EVT(E)) dut (
        .clk(clk), .rst_n(rst_n), .csr_re(csr_re), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .retire(retire), .evt(evt));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model state
    longint unsigned m_cyc, m_ir[H], m_ev[H][E], m_rd[H];
    bit m_cy, m_irinh[H];
    bit [E-1:0] m_evinh[H];

    // Next-cycle stimulus
    bit [H-1:0] n_re, n_we, n_ret;
    bit [H-1:0][5:0] n_sel;
    bit [H-1:0][W-1:0] n_wd;
    bit [H-1:0][E-1:0] n_evt;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R11";

    function automatic longint unsigned model_read(int h, int s);
        longint unsigned v = 0;
        if (s == 32) begin
            v[0] = m_cy; v[2] = m_irinh[h];
            for (int k = 0; k < E; k++) v[3+k] = m_evinh[h][k];
        end else if (s == 0) v = m_cyc;
        else if (s == 2) v = m_ir[h];
        else if (s >= 3 && s < 3 + E) v = m_ev[h][s-3];
        return v;
    endfunction

    task automatic compare();
        for (int h = 0; h < H; h++) begin
            checks++;
            if (csr_rdata[h] !== m_rd[h]) begin
                fails++;
                $display("FAIL %s hart%0d rdata actual=%h expected=%h",
                         tag, h, csr_rdata[h], m_rd[h]);
            end
        end
    endtask

    // Apply stimulus to the DUT and advance the model by one clock.
    task automatic drive();
        longint unsigned c_n, ir_n[H], ev_n[H][E];
        bit cy_n, irinh_n[H];
        bit [E-1:0] evinh_n[H];
        csr_re = n_re; csr_we = n_we; csr_sel = n_sel; csr_wdata = n_wd;
        retire = n_ret; evt = n_evt;
        for (int h = 0; h < H; h++)
            if (n_re[h]) m_rd[h] = model_read(h, int'(n_sel[h]));
        c_n = m_cy ? m_cyc : m_cyc + 1;
        cy_n = m_cy;
        for (int h = H - 1; h >= 0; h--) begin
            if (n_we[h] && n_sel[h] == 0)  c_n = n_wd[h];
            if (n_we[h] && n_sel[h] == 32) cy_n = n_wd[h][0];
        end
        for (int h = 0; h < H; h++) begin
            ir_n[h] = (n_ret[h] && !m_irinh[h]) ? m_ir[h] + 1 : m_ir[h];
            if (n_we[h] && n_sel[h] == 2) ir_n[h] = n_wd[h];
            for (int k = 0; k < E; k++) begin
                ev_n[h][k] = (n_evt[h][k] && !m_evinh[h][k]) ? m_ev[h][k] + 1 : m_ev[h][k];
                if (n_we[h] && n_sel[h] == 6'(3 + k)) ev_n[h][k] = n_wd[h];
            end
            irinh_n[h] = m_irinh[h]; evinh_n[h] = m_evinh[h];
            if (n_we[h] && n_sel[h] == 32) begin
                irinh_n[h] = n_wd[h][2]; evinh_n[h] = n_wd[h][3 +: E];
            end
        end
        m_cyc = c_n; m_cy = cy_n;
        for (int h = 0; h < H; h++) begin
            m_ir[h] = ir_n[h]; m_irinh[h] = irinh_n[h]; m_evinh[h] = evinh_n[h];
            for (int k = 0; k < E; k++) m_ev[h][k] = ev_n[h][k];
        end
        n_re = '0; n_we = '0; n_ret = '0; n_sel = '0; n_wd = '0; n_evt = '0;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        drive();
    endtask

    task automatic wr(int h, int s, longint unsigned d);
        n_we[h] = 1'b1; n_sel[h] = 6'(s); n_wd[h] = d;
    endtask

    task automatic rd(int h, int s);
        n_re[h] = 1'b1; n_sel[h] = 6'(s);
    endtask

    task automatic read_all(int h);
        for (int s = 0; s < 64; s++) begin rd(h, s); step(); end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++; fails++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        m_cyc = 0; m_cy = 0;
        for (int h = 0; h < H; h++) begin
            m_ir[h] = 0; m_rd[h] = 0; m_irinh[h] = 0; m_evinh[h] = '0;
            for (int k = 0; k < E; k++) m_ev[h][k] = 0;
        end
        n_re = '0; n_we = '0; n_ret = '0; n_sel = '0; n_wd = '0; n_evt = '0;
        repeat (3) @(negedge clk);
        tag = "R11 reset";
        compare();
        rst_n = 1'b1;
        drive();
        read_all(0);

        tag = "R1 R2 cycle write by hart1 seen by hart0";
        wr(1, 0, 64'h1234_5678_0000_0010); step();
        rd(0, 0); rd(1, 0); step(); step();

        tag = "R4 simultaneous cycle writes";
        wr(0, 0, 64'hAAAA); wr(1, 0, 64'hBBBB); step();
        rd(0, 0); step(); step();

        tag = "R3 R1 shared cycle inhibit";
        wr(1, 32, 64'h1); step();
        rd(0, 0); step(); rd(0, 0); step(); rd(0, 32); step(); step();
        tag = "R4 simultaneous inhibit writes";
        wr(0, 32, 64'h0); wr(1, 32, 64'h1); step();
        rd(1, 0); step(); rd(1, 0); step(); step();

        tag = "R5 R7 retire with same-cycle write and wrap";
        wr(0, 2, 64'hFFFF_FFFF_FFFF_FFFF); n_ret[0] = 1; step();
        n_ret[0] = 1; step();
        rd(0, 2); rd(1, 2); step(); step();
        tag = "R5 R10 private retire inhibit";
        wr(1, 32, 64'h4); step();
        n_ret = '1; step(); n_ret = '1; step();
        rd(0, 2); rd(1, 2); step(); rd(1, 32); rd(0, 32); step(); step();

        tag = "R6 R7 events with write and inhibit";
        for (int i = 0; i < 4; i++) begin n_evt[0] = '1; n_evt[1] = E'(32'h5555_5555); step(); end
        wr(0, 5, 64'h77); n_evt[0] = '1; step();
        wr(0, 32, 64'h0000_0000_0000_0010); step();
        for (int i = 0; i < 3; i++) begin n_evt[0] = '1; step(); end
        read_all(0); read_all(1);

        tag = "R9 R10 reserved selectors and bits";
        wr(0, 1, 64'hDEAD); wr(1, 40, 64'hBEEF); step();
        wr(0, 63, 64'h1); wr(1, 33, 64'h2); step();
        wr(0, 32, 64'hFFFF_FFFF_FFFF_FFFF); step();
        read_all(0); read_all(1);
        wr(0, 32, 64'h0); wr(1, 32, 64'h0); step();

        tag = "R1-R10 random traffic R8";
        for (int i = 0; i < 3000; i++) begin
            for (int h = 0; h < H; h++) begin
                int pick = int'($urandom_range(0, 9));
                int s;
                case (pick)
                    0: s = 0; 1: s = 1; 2: s = 2; 3: s = 32; 4: s = 33;
                    default: s = int'($urandom_range(3, 31));
                endcase
                n_sel[h] = 6'(s);
                n_re[h]  = ($urandom_range(0, 2) != 0);
                n_we[h]  = ($urandom_range(0, 7) == 0);
                n_wd[h]  = ($urandom_range(0, 3) == 0) ? 64'hFFFF_FFFF_FFFF_FFFE
                           : {$urandom, $urandom};
                if (s == 32 && n_we[h]) n_wd[h] = {32'h0, $urandom} & 64'hFFFF_FFFF_0000_F00F;
                n_ret[h] = $urandom_range(0, 1) != 0;
                n_evt[h] = E'($urandom);
            end
            step();
        end
        step();
        finish_run();
    end
endmodule